// File: doc/BRIEF.md
# SDRAM Power-Up Initialization Sequencer

This block brings a single-partition SDR SDRAM from power-on to normal operation. After reset it idles until a `start` pulse. Then it waits a programmable stabilisation time and latches the refresh-interval value and the row-address code. It waits a second stabilisation time and issues PRECHARGE-ALL followed by exactly eight AUTO-REFRESH commands. Each command is followed by a programmable idle gap. Only then does it enable the partition, issue a MODE-REGISTER-SET with an all-zero mode value, and wait out the mode-register delay. After that delay it raises `done` and keeps it high.

Once `done` is high, an internal refresh timer runs. It counts the programmed interval in units of 32 clocks and raises a refresh request each time it expires. The request stays high until the memory controller acknowledges it. The interval value is derived from the clock frequency and the device row count as floor(floor(64 ms × f / rows) / 32). That gives 48 for a 4096-row device at 99.5 MHz and 24 for an 8192-row device.

Top module: `sdram_init_seq`

## Requirements
- R1: While reset is held and after its release until `start`, `cmdOut` is NOP (0), `done`, `partEn` and `refreshReq` are 0, and `intervalOut` is 0.
- R2: A `start` sampled at edge c gives NOP for WAIT_CYCLES cycles. The configuration is loaded in cycle c+WAIT_CYCLES, so `intervalOut`/`rowCode` are valid from cycle c+WAIT_CYCLES+1. A second NOP wait of WAIT_CYCLES cycles follows, and PRECHARGE-ALL appears in cycle c+2·WAIT_CYCLES+1.
- R3: `intervalOut` (12 bits) equals floor(floor(64·CLK_KHZ/ROWS)/32). `rowCode` is 1 for 4096 rows and 2 for 8192 rows.
- R4: Command codes are NOP=0, PRECHARGE-ALL=1, AUTO-REFRESH=2, MODE-REGISTER-SET=3. PRECHARGE-ALL drives address bit 10 high.
- R5: Exactly eight AUTO-REFRESH commands follow PRECHARGE-ALL. Each comes TRC_CYCLES+1 cycles after the previous command, with NOP in between.
- R6: `partEn` stays 0 through the eighth AUTO-REFRESH and its gap, and is 1 from the MODE-REGISTER-SET cycle on. MODE-REGISTER-SET comes TRC_CYCLES+2 cycles after the eighth AUTO-REFRESH, with an all-zero address.
- R7: `done` rises TMRD_CYCLES+1 cycles after MODE-REGISTER-SET and stays high.
- R8: With `done` high, `refreshReq` rises INTERVAL·32 cycles after `done` rises and every INTERVAL·32 cycles after that. It holds until `refreshAck` is sampled high and is low in the following cycle.
- R9: `start` is ignored once the sequence has begun. No command is issued and the timing is unchanged.
- R10: `cke` is high whenever reset is released.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| start | input | 1 | Begins the power-up sequence |
| refreshAck | input | 1 | Acknowledges a pending refresh request |
| cmdOut | output | 2 | SDRAM command code (R4) |
| addrOut | output | ADDR_W | SDRAM address bus |
| cke | output | 1 | Clock enable to the SDRAM |
| partEn | output | 1 | Partition enable |
| rowCode | output | 2 | Row-address width code |
| intervalOut | output | 12 | Refresh interval in units of 32 clocks |
| refreshReq | output | 1 | Periodic refresh request |
| done | output | 1 | Initialization finished |

## Verification
On every cycle the assertions enforce the following. `done` and `partEn` never fall once set. MODE-REGISTER-SET is never issued without the partition enabled, and no AUTO-REFRESH is issued after the eighth. A pending refresh request survives until acknowledged, and no request appears before `done`. The exact cycle spacing is shown only by the bench's scenarios: the two waits, the gaps between commands, the `done` delay and the refresh period. The same holds for the address values, the configuration outputs, and the fact that a late `start` has no effect.

// File: rtl/sdram_init_pkg.sv
package sdram_init_pkg;

  typedef enum logic [1:0] {
    CMD_NOP  = 2'd0,
    CMD_PALL = 2'd1,
    CMD_AREF = 2'd2,
    CMD_MRS  = 2'd3
  } sdramCmd_e;

  localparam int NUM_REFS = 8;

  // strobes from control to datapath
  typedef struct packed {
    logic ldLong;
    logic ldTrc;
    logic ldMrd;
    logic cfgLoad;
    logic refInc;
    logic enPart;
    logic setDone;
  } initStrb_t;

  // status from datapath to control
  typedef struct packed {
    logic waitZero;
    logic refDone;
    logic partEn;
  } initStat_t;

  function automatic int calcInterval(input int clkKhz, input int rows);
    int perRow;
    perRow = (64 * clkKhz) / rows;
    return perRow / 32;
  endfunction

endpackage

// File: rtl/sdram_init_ctrl.sv
module sdram_init_ctrl
  import sdram_init_pkg::*;
#(
  parameter int ADDR_W = 13
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              start,
  input  initStat_t         stat,
  output initStrb_t         strb,
  output logic [1:0]        cmdOut,
  output logic [ADDR_W-1:0] addrOut
);

  typedef enum logic [3:0] {
    S_IDLE, S_WAIT1, S_CFG, S_WAIT2, S_PALL, S_GAP,
    S_REF, S_ENA, S_MRS, S_MRDW, S_DONE
  } state_e;

  state_e state, nextState;

  always_ff @(posedge clk) begin
    if (!rstN) state <= S_IDLE;
    else       state <= nextState;
  end

  always_comb begin
    nextState = state;
    strb      = '0;
    cmdOut    = CMD_NOP;
    addrOut   = '0;
    unique case (state)
      S_IDLE: if (start) begin
        strb.ldLong = 1'b1;
        nextState   = S_WAIT1;
      end
      S_WAIT1: if (stat.waitZero) nextState = S_CFG;
      S_CFG: begin
        strb.cfgLoad = 1'b1;
        strb.ldLong  = 1'b1;
        nextState    = S_WAIT2;
      end
      S_WAIT2: if (stat.waitZero) nextState = S_PALL;
      S_PALL: begin
        cmdOut      = CMD_PALL;
        addrOut[10] = 1'b1;
        strb.ldTrc  = 1'b1;
        nextState   = S_GAP;
      end
      S_GAP: if (stat.waitZero) nextState = stat.refDone ? S_ENA : S_REF;
      S_REF: begin
        cmdOut      = CMD_AREF;
        strb.refInc = 1'b1;
        strb.ldTrc  = 1'b1;
        nextState   = S_GAP;
      end
      S_ENA: begin
        strb.enPart = 1'b1;
        nextState   = S_MRS;
      end
      S_MRS: begin
        cmdOut     = CMD_MRS;
        strb.ldMrd = 1'b1;
        nextState  = S_MRDW;
      end
      S_MRDW: if (stat.waitZero) begin
        strb.setDone = 1'b1;
        nextState    = S_DONE;
      end
      S_DONE: nextState = S_DONE;
      default: nextState = S_IDLE;
    endcase
  end

  // R6: mode-register-set only with the partition already enabled
  a_r6_mrs_needs_enable: assert property (@(posedge clk) disable iff (!rstN)
    (state == S_MRS) |-> stat.partEn);

  // R5: no refresh beyond the eighth
  a_r5_no_ninth_ref: assert property (@(posedge clk) disable iff (!rstN)
    (state == S_REF) |-> !stat.refDone);

endmodule

// File: rtl/sdram_init_dp.sv
module sdram_init_dp
  import sdram_init_pkg::*;
#(
  parameter int WAIT_CYCLES = 9984,
  parameter int TRC_CYCLES  = 7,
  parameter int TMRD_CYCLES = 2,
  parameter int INTERVAL    = 48,
  parameter int CNT_W       = 14
) (
  input  logic        clk,
  input  logic        rstN,
  input  initStrb_t   strb,
  input  logic        refreshAck,
  output initStat_t   stat,
  output logic [11:0] intervalOut,
  output logic        cfgValid,
  output logic        partEn,
  output logic        refreshReq,
  output logic        done
);

  localparam int PERIOD = INTERVAL * 32;
  localparam int TMR_W  = $clog2(PERIOD + 1);
  localparam logic [CNT_W-1:0] LONG_LD = CNT_W'(WAIT_CYCLES - 1);
  localparam logic [CNT_W-1:0] TRC_LD  = CNT_W'(TRC_CYCLES - 1);
  localparam logic [CNT_W-1:0] MRD_LD  = CNT_W'(TMRD_CYCLES - 1);
  localparam logic [TMR_W-1:0] PER_LD  = TMR_W'(PERIOD - 1);
  localparam logic [3:0]       REF_N   = 4'(NUM_REFS);

  logic [CNT_W-1:0] waitCnt;
  logic [3:0]       refCnt;
  logic [TMR_W-1:0] refTmr;
  logic             expire;

  // shared wait counter for stabilisation, tRC and tMRD delays
  always_ff @(posedge clk) begin
    if (!rstN)             waitCnt <= '0;
    else if (strb.ldLong)  waitCnt <= LONG_LD;
    else if (strb.ldTrc)   waitCnt <= TRC_LD;
    else if (strb.ldMrd)   waitCnt <= MRD_LD;
    else if (waitCnt != 0) waitCnt <= waitCnt - 1'b1;
  end

  always_ff @(posedge clk) begin
    if (!rstN)            refCnt <= '0;
    else if (strb.refInc) refCnt <= refCnt + 1'b1;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      intervalOut <= '0;
      cfgValid    <= 1'b0;
      partEn      <= 1'b0;
      done        <= 1'b0;
    end else begin
      if (strb.cfgLoad) begin
        intervalOut <= 12'(INTERVAL);
        cfgValid    <= 1'b1;
      end
      if (strb.enPart)  partEn <= 1'b1;
      if (strb.setDone) done   <= 1'b1;
    end
  end

  // periodic refresh timer, free-running once done
  assign expire = done && (refTmr == '0);

  always_ff @(posedge clk) begin
    if (!rstN)       refTmr <= '0;
    else if (!done)  refTmr <= PER_LD;
    else if (expire) refTmr <= PER_LD;
    else             refTmr <= refTmr - 1'b1;
  end

  always_ff @(posedge clk) begin
    if (!rstN)           refreshReq <= 1'b0;
    else if (expire)     refreshReq <= 1'b1;
    else if (refreshAck) refreshReq <= 1'b0;
  end

  assign stat.waitZero = (waitCnt == '0);
  assign stat.refDone  = (refCnt == REF_N);
  assign stat.partEn   = partEn;

  a_r7_done_sticky: assert property (@(posedge clk) disable iff (!rstN)
    done |=> done);

  a_r6_enable_sticky: assert property (@(posedge clk) disable iff (!rstN)
    partEn |=> partEn);

  a_r8_req_held: assert property (@(posedge clk) disable iff (!rstN)
    (refreshReq && !refreshAck) |=> refreshReq);

  a_r1_no_req_before_done: assert property (@(posedge clk) disable iff (!rstN)
    !done |-> !refreshReq);

  a_r5_ref_count_bound: assert property (@(posedge clk) disable iff (!rstN)
    refCnt <= REF_N);

endmodule

// File: rtl/sdram_init_seq.sv
module sdram_init_seq
  import sdram_init_pkg::*;
#(
  parameter int WAIT_CYCLES = 9984,
  parameter int TRC_CYCLES  = 7,
  parameter int TMRD_CYCLES = 2,
  parameter int ROWS        = 4096,
  parameter int CLK_KHZ     = 99500,
  parameter int ADDR_W      = 13
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              start,
  input  logic              refreshAck,
  output logic [1:0]        cmdOut,
  output logic [ADDR_W-1:0] addrOut,
  output logic              cke,
  output logic              partEn,
  output logic [1:0]        rowCode,
  output logic [11:0]       intervalOut,
  output logic              refreshReq,
  output logic              done
);

  localparam int INTERVAL = calcInterval(CLK_KHZ, ROWS);
  localparam int MAX_LD   = (WAIT_CYCLES > TRC_CYCLES) ?
                            ((WAIT_CYCLES > TMRD_CYCLES) ? WAIT_CYCLES : TMRD_CYCLES) :
                            ((TRC_CYCLES > TMRD_CYCLES) ? TRC_CYCLES : TMRD_CYCLES);
  localparam int CNT_W    = $clog2(MAX_LD + 1);
  localparam logic [1:0] ROW_CODE = (ROWS >= 8192) ? 2'd2 : 2'd1;

  initStrb_t strb;
  initStat_t stat;
  logic      cfgValid;

  sdram_init_ctrl #(.ADDR_W(ADDR_W)) u_ctrl (
    .clk     (clk),
    .rstN    (rstN),
    .start   (start),
    .stat    (stat),
    .strb    (strb),
    .cmdOut  (cmdOut),
    .addrOut (addrOut)
  );

  sdram_init_dp #(
    .WAIT_CYCLES (WAIT_CYCLES),
    .TRC_CYCLES  (TRC_CYCLES),
    .TMRD_CYCLES (TMRD_CYCLES),
    .INTERVAL    (INTERVAL),
    .CNT_W       (CNT_W)
  ) u_dp (
    .clk         (clk),
    .rstN        (rstN),
    .strb        (strb),
    .refreshAck  (refreshAck),
    .stat        (stat),
    .intervalOut (intervalOut),
    .cfgValid    (cfgValid),
    .partEn      (partEn),
    .refreshReq  (refreshReq),
    .done        (done)
  );

  assign rowCode = cfgValid ? ROW_CODE : 2'd0;
  assign cke     = 1'b1;

endmodule

// File: tb/sdram_init_seq_tb.sv
module sdram_init_seq_tb;

  localparam int CLK_PERIOD = 10;
  localparam int WAIT_C  = 20;
  localparam int TRC_C   = 3;
  localparam int TMRD_C  = 2;
  localparam int ROWS_C  = 4096;
  localparam int KHZ_C   = 4096;
  localparam int EXP_INT = ((64 * KHZ_C) / ROWS_C) / 32;
  localparam int PER     = EXP_INT * 32;
  localparam int G       = TRC_C + 1;
  localparam int EV_N    = 10;
  localparam int evCmd [EV_N] = '{1, 2, 2, 2, 2, 2, 2, 2, 2, 3};
  localparam int evOff [EV_N] = '{0, G, 2*G, 3*G, 4*G, 5*G, 6*G, 7*G, 8*G, 8*G + TRC_C + 2};

  logic clk = 1'b0, rstN = 1'b0, start = 1'b0, refreshAck = 1'b0;
  logic [1:0]  cmdOut, rowCode;
  logic [12:0] addrOut;
  logic        cke, partEn, refreshReq, done;
  logic [11:0] intervalOut;

  int cyc = 0, total = 0, bad = 0;
  int startCyc, pallCyc, mrsCyc, doneCyc, guard;

  always #(CLK_PERIOD/2) clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  sdram_init_seq #(
    .WAIT_CYCLES(WAIT_C), .TRC_CYCLES(TRC_C), .TMRD_CYCLES(TMRD_C),
    .ROWS(ROWS_C), .CLK_KHZ(KHZ_C), .ADDR_W(13)
  ) u_dut (
    .clk(clk), .rstN(rstN), .start(start), .refreshAck(refreshAck),
    .cmdOut(cmdOut), .addrOut(addrOut), .cke(cke), .partEn(partEn),
    .rowCode(rowCode), .intervalOut(intervalOut), .refreshReq(refreshReq),
    .done(done)
  );

  task automatic chk(input string tag, input int act, input int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s: actual=%0d expected=%0d (cycle %0d)", tag, act, exp, cyc);
    end
  endtask

  task automatic summary;
    $display("  test done: total=%0d bad=%0d", total, bad);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    bad++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    summary();
    $finish;
  end

  initial begin
    // R1 reset state
    repeat (3) @(negedge clk);
    chk("R1 cmd", cmdOut, 0);
    chk("R1 done", done, 0);
    chk("R1 partEn", partEn, 0);
    chk("R1 interval", intervalOut, 0);
    rstN = 1'b1;
    repeat (4) @(negedge clk);
    chk("R1 idle cmd", cmdOut, 0);
    chk("R1 idle req", refreshReq, 0);
    chk("R10 cke", cke, 1);

    // start, R2 first wait
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    startCyc = cyc;
    while (cyc < startCyc + WAIT_C + 1) begin
      if (cmdOut != 0 || intervalOut != 0) chk("R2 first wait quiet", {cmdOut, intervalOut}, 0);
      @(negedge clk);
    end
    chk("R2 config loaded", intervalOut, EXP_INT);
    chk("R3 interval", intervalOut, EXP_INT);
    chk("R3 rowCode", rowCode, 1);
    // R9 start during second wait
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;

    // walk the expected command table (R4 R5 R6)
    pallCyc = 0;
    for (int i = 0; i < EV_N; i++) begin
      guard = 0;
      if (i > 0) @(negedge clk);
      while (cmdOut == 0 && guard < 5000) begin
        if (cke != 1'b1) chk("R10 cke", cke, 1);
        @(negedge clk);
        guard++;
      end
      if (i == 0) begin
        pallCyc = cyc;
        chk("R2 R9 precharge time", cyc - startCyc, 2 * WAIT_C + 1);
        chk("R4 precharge a10", addrOut[10], 1);
      end
      chk("R4 R5 cmd code", cmdOut, evCmd[i]);
      chk("R5 R6 cmd offset", cyc - pallCyc, evOff[i]);
      chk("R6 partEn", partEn, (i == EV_N - 1) ? 1 : 0);
      if (i == EV_N - 1) begin
        chk("R6 mrs addr", addrOut, 0);
        mrsCyc = cyc;
      end
    end

    // R7 done timing
    while (cyc < mrsCyc + TMRD_C) @(negedge clk);
    chk("R7 done early", done, 0);
    @(negedge clk);
    chk("R7 done rise", done, 1);
    doneCyc = cyc;

    // R8 refresh request timing and hold
    while (cyc < doneCyc + PER - 1) @(negedge clk);
    chk("R8 req before expiry", refreshReq, 0);
    @(negedge clk);
    chk("R8 req at expiry", refreshReq, 1);
    repeat (10) @(negedge clk);
    chk("R8 req held", refreshReq, 1);
    refreshAck = 1'b1;
    @(negedge clk);
    refreshAck = 1'b0;
    chk("R8 req cleared", refreshReq, 0);
    while (cyc < doneCyc + 2 * PER) @(negedge clk);
    chk("R8 second expiry", refreshReq, 1);
    refreshAck = 1'b1;
    @(negedge clk);
    refreshAck = 1'b0;

    // R9 start after done has no effect
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    for (int k = 0; k < 80; k++) begin
      if (cmdOut != 0) chk("R9 no command after done", cmdOut, 0);
      @(negedge clk);
    end
    chk("R9 done kept", done, 1);
    chk("R9 partEn kept", partEn, 1);
    chk("R7 done stays", done, 1);

    summary();
    $finish;
  end

endmodule